// File: doc/BRIEF.md
# Clock-edge trace aligner and averager

This block sums many sampled power traces into one array while correcting for clock jitter. Samples arrive one at a time, each with a valid strobe. The first sample of a trace carries a start marker and the last sample carries an end marker. The first clock period of each trace is summed at fixed positions. For every later clock period, the block looks for the steepest rising edge in the samples and treats it as the true start of that clock. One period of samples, taken from that edge, is then added into the next block of accumulator slots.

Sample values are buffered in a ring, so the edge search and the summing can read them independently. The edge search runs as the samples stream in. The summing engine then reads one period's worth from the buffer, starting at the chosen edge. Traces are added one after another into the same array until a synchronous clear. A registered read port gives the current sums. Detecting the trigger and dividing the sums into a mean are done elsewhere.

Top module: `trace_aligner`

## Requirements
- R1: After reset, every accumulator slot reads zero. Read data appears on `rd_data_o` one clock after its address is presented on `rd_addr_i`.
- R2: Sample indices 0 to 249 of a trace (index 0 carries the start marker) are added into slots 0 to 249 at the same index, with no search.
- R3: The first edge search starts at index 225 of the trace. Each later search starts 225 samples after the previously chosen edge. Each search covers exactly 100 candidate positions.
- R4: Each candidate j is scored as sample[j+5] minus sample[j]. The edge is the candidate with the largest positive score. On a tie, the earliest candidate wins.
- R5: If no candidate in a window has a positive score, the first position of the window is used as the edge.
- R6: The 250 samples that start at the chosen edge are added into the next block of 250 slots. The first edge goes to slots 250 to 499, the next to slots 500 to 749, and so on.
- R7: When a trace ends, its last block receives only the samples up to the trace's final sample. A block is created only if its search window completed, which needs sample index (window start + 104) to be present.
- R8: The array holds 4 blocks (1000 slots). Once the fourth block has been started, the rest of the trace adds nothing.
- R9: A later trace adds into the same array, so each slot holds the sum over all traces.
- R10: Valid samples that arrive outside a trace (before any start marker or after an end marker) change no slot.
- R11: A synchronous clear sets every slot to zero and abandons any trace in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the array and all state |
| smp_valid_i | input | 1 | Sample strobe |
| smp_start_i | input | 1 | Marks the first sample of a trace |
| smp_end_i | input | 1 | Marks the last sample of a trace |
| smp_data_i | input | 8 | Unsigned sample value |
| rd_addr_i | input | 10 | Accumulator slot to read |
| rd_data_o | output | 24 | Sum held in the addressed slot, registered |

## Verification
The assertions rely on three conditions. A valid sample is never followed by another valid sample in the next clock. A new start marker comes only after the previous trace's last block has been fully added. Traces are shorter than 65536 samples. Under these conditions the summing engine never falls more than about 105 samples behind the input, the ring is never overrun, and a new edge is never found while a block is still being added. The bench drives each sample for one clock followed by one idle clock, and waits 400 idle clocks after every trace before the next stimulus.

// File: rtl/ta_pkg.sv
package ta_pkg;
  localparam int unsigned SMP_W = 8;
  localparam int unsigned ACC_W = 24;
  localparam int unsigned IDX_W = 16;

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [ACC_W-1:0] acc_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/ta_sample_buf.sv
module ta_sample_buf
  import ta_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  smp_t          wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output smp_t          ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output smp_t          rb_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  smp_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/ta_edge_search.sv
module ta_edge_search
  import ta_pkg::*;
#(
  parameter int unsigned WIN = 100,
  parameter int unsigned LAG = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  idx_t arm_pos_i,
  input  logic stop_i,
  input  logic valid_i,
  input  idx_t idx_i,
  input  smp_t cur_i,
  input  smp_t old_i,
  output logic found_o,
  output idx_t edge_o
);
  logic                    active_q, found_q;
  idx_t                    ws_q, pos_q, edge_q;
  logic signed [SMP_W:0]   best_q, diff;
  idx_t                    lo, hi;
  logic                    in_win, better, last;

  assign lo     = ws_q + idx_t'(LAG);
  assign hi     = ws_q + idx_t'(LAG + WIN - 1);
  assign diff   = $signed({1'b0, cur_i}) - $signed({1'b0, old_i});
  assign in_win = active_q && valid_i && (idx_i >= lo) && (idx_i <= hi);
  assign better = in_win && (diff > best_q);   // strict: earliest wins ties
  assign last   = in_win && (idx_i == hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      found_q  <= 1'b0;
      ws_q     <= '0;
      pos_q    <= '0;
      edge_q   <= '0;
      best_q   <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      found_q  <= 1'b0;
    end else begin
      found_q <= 1'b0;
      if (arm_i) begin
        active_q <= 1'b1;
        ws_q     <= arm_pos_i;
        pos_q    <= arm_pos_i;   // fallback when nothing positive
        best_q   <= '0;
      end else begin
        if (in_win) begin
          if (better) begin
            best_q <= diff;
            pos_q  <= idx_i - idx_t'(LAG);
          end
          if (last) begin
            active_q <= 1'b0;
            found_q  <= 1'b1;
            edge_q   <= better ? idx_i - idx_t'(LAG) : pos_q;
          end
        end
        if (stop_i) active_q <= 1'b0;
      end
    end
  end

  assign found_o = found_q;
  assign edge_o  = edge_q;

  p_edge_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (edge_o >= ws_q) && (edge_o < ws_q + idx_t'(WIN)));

  p_found_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> !found_o);
endmodule

// File: rtl/ta_acc_array.sv
module ta_acc_array
  import ta_pkg::*;
#(
  parameter int unsigned SLOTS = 1000,
  localparam int unsigned AW   = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  smp_t          wval_i,
  input  logic [AW-1:0] raddr_i,
  output acc_t          rdata_o
);
  acc_t mem_q [SLOTS];
  acc_t rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= mem_q[waddr_i] + acc_t'(wval_i);
      rdata_q <= (int'(raddr_i) < SLOTS) ? mem_q[raddr_i] : '0;
    end
  end

  assign rdata_o = rdata_q;

  p_slot_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> int'(waddr_i) < SLOTS);

  p_clear_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rdata_o == '0);
endmodule

// File: rtl/trace_aligner.sv
module trace_aligner
  import ta_pkg::*;
#(
  parameter int unsigned CLK_SAMPLES = 250,
  parameter int unsigned NUM_BLOCKS  = 4,
  parameter int unsigned SKIP_PCT    = 90,
  parameter int unsigned WIN_PCT     = 40,
  parameter int unsigned LAG_DIV     = 50
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       clr_i,
  input  logic                                       smp_valid_i,
  input  logic                                       smp_start_i,
  input  logic                                       smp_end_i,
  input  logic [SMP_W-1:0]                           smp_data_i,
  input  logic [$clog2(CLK_SAMPLES*NUM_BLOCKS)-1:0]  rd_addr_i,
  output logic [ACC_W-1:0]                           rd_data_o
);
  localparam int unsigned SKIP      = CLK_SAMPLES * SKIP_PCT / 100;
  localparam int unsigned WIN       = CLK_SAMPLES * WIN_PCT / 100;
  localparam int unsigned LAG       = CLK_SAMPLES / LAG_DIV;
  localparam int unsigned SLOTS     = CLK_SAMPLES * NUM_BLOCKS;
  localparam int unsigned AW        = $clog2(SLOTS);
  localparam int unsigned CW        = $clog2(CLK_SAMPLES);
  localparam int unsigned BW        = $clog2(NUM_BLOCKS + 1);
  localparam int unsigned BAW       = $clog2(2 * CLK_SAMPLES);
  localparam int unsigned BUF_DEPTH = 1 << BAW;

  logic          in_trace_q, acc_act_q;
  idx_t          n_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] blk_q;

  logic          take, first, have, arm, found;
  idx_t          arm_pos, edge_idx;
  smp_t          old_smp, acc_smp;

  assign take  = smp_valid_i && (smp_start_i || in_trace_q);
  assign first = take && smp_start_i;
  assign have  = acc_act_q && (rp_q < n_q);

  ta_sample_buf #(.AW(BAW)) u_buf (
    .clk_i     (clk_i),
    .we_i      (take),
    .waddr_i   (smp_start_i ? '0 : n_q[BAW-1:0]),
    .wdata_i   (smp_data_i),
    .ra_addr_i (n_q[BAW-1:0] - BAW'(LAG)),
    .ra_data_o (old_smp),
    .rb_addr_i (rp_q[BAW-1:0]),
    .rb_data_o (acc_smp)
  );

  assign arm     = (first && (NUM_BLOCKS > 1)) ||
                   (found && in_trace_q && (int'(blk_q) + 1 < NUM_BLOCKS));
  assign arm_pos = first ? idx_t'(SKIP) : edge_idx + idx_t'(SKIP);

  ta_edge_search #(.WIN(WIN), .LAG(LAG)) u_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .arm_i     (arm),
    .arm_pos_i (arm_pos),
    .stop_i    (take && (smp_end_i || smp_start_i)),
    .valid_i   (take && !smp_start_i),
    .idx_i     (n_q),
    .cur_i     (smp_data_i),
    .old_i     (old_smp),
    .found_o   (found),
    .edge_o    (edge_idx)
  );

  ta_acc_array #(.SLOTS(SLOTS)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .we_i    (have),
    .waddr_i (base_q + AW'(cnt_q)),
    .wval_i  (acc_smp),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_trace_q <= 1'b0;
      acc_act_q  <= 1'b0;
      n_q        <= '0;
      rp_q       <= '0;
      cnt_q      <= '0;
      base_q     <= '0;
      blk_q      <= '0;
    end else if (clr_i) begin
      in_trace_q <= 1'b0;
      acc_act_q  <= 1'b0;
      n_q        <= '0;
      rp_q       <= '0;
      cnt_q      <= '0;
      base_q     <= '0;
      blk_q      <= '0;
    end else begin
      if (take) begin
        n_q        <= smp_start_i ? idx_t'(1) : n_q + idx_t'(1);
        in_trace_q <= !smp_end_i;
      end
      if (first) begin
        acc_act_q <= 1'b1;
        rp_q      <= '0;
        cnt_q     <= '0;
        base_q    <= '0;
        blk_q     <= BW'(1);
      end else if (found && (int'(blk_q) < NUM_BLOCKS)) begin
        acc_act_q <= 1'b1;
        rp_q      <= edge_idx;
        cnt_q     <= '0;
        base_q    <= base_q + AW'(CLK_SAMPLES);
        blk_q     <= blk_q + BW'(1);
      end else if (have) begin
        rp_q  <= rp_q + idx_t'(1);
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(CLK_SAMPLES - 1)) acc_act_q <= 1'b0;
      end else if (acc_act_q && !in_trace_q) begin
        acc_act_q <= 1'b0;   // trace over, partial block done
      end
    end
  end

  p_valid_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> !smp_valid_i);

  p_start_drained_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_start_i) |-> !acc_act_q);

  p_no_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_act_q |-> idx_t'(n_q - rp_q) < idx_t'(BUF_DEPTH));

  p_edge_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> !acc_act_q);

  p_block_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(blk_q) <= NUM_BLOCKS);
endmodule

// File: tb/sim_trace_aligner.sv
module sim_trace_aligner;
  localparam int CLKP  = 250;
  localparam int NB    = 4;
  localparam int SLOTS = CLKP * NB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       vld = 1'b0, st = 1'b0, en = 1'b0;
  logic [7:0] dat = '0;
  logic [9:0] raddr = '0;
  logic [23:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] tr [0:2047];
  int exp_acc [0:SLOTS-1];

  always #10 clk = ~clk;

  trace_aligner u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .smp_valid_i(vld), .smp_start_i(st), .smp_end_i(en), .smp_data_i(dat),
    .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  task automatic read_slot(input int a, output int v);
    @(negedge clk) raddr = 10'(a);
    @(negedge clk) v = int'(rdata);
  endtask

  task automatic check_slot(input string req, input int a, input int expv);
    int v;
    read_slot(a, v);
    checks++;
    if (v != expv) begin
      errors++;
      $display("FAIL %s slot %0d: got %0d expected %0d", req, a, v, expv);
    end
  endtask

  task automatic check_all(input string req);
    int v;
    bit bad = 0;
    checks++;
    for (int a = 0; a < SLOTS; a++) begin
      read_slot(a, v);
      if (!bad && v != exp_acc[a]) begin
        bad = 1; errors++;
        $display("FAIL %s slot %0d: got %0d expected %0d", req, a, v, exp_acc[a]);
      end
    end
  endtask

  task automatic zero_model();
    for (int a = 0; a < SLOTS; a++) exp_acc[a] = 0;
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    zero_model();
  endtask

  // reference built from the requirements
  task automatic model_add(input int len);
    int e, ws, best, pos, d;
    for (int k = 0; k < CLKP && k < len; k++) exp_acc[k] += int'(tr[k]);
    e = 0;
    for (int b = 1; b < NB; b++) begin
      ws = e + 225;
      if (ws + 104 > len - 1) break;
      best = 0; pos = ws;
      for (int j = ws; j < ws + 100; j++) begin
        d = int'(tr[j+5]) - int'(tr[j]);
        if (d > best) begin best = d; pos = j; end
      end
      e = pos;
      for (int k = 0; k < CLKP && e + k < len; k++) exp_acc[b*CLKP+k] += int'(tr[e+k]);
    end
  endtask

  task automatic send(input int len, input bit marks);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      vld = 1'b1; dat = tr[k];
      st = marks && (k == 0);
      en = marks && (k == len - 1);
      @(negedge clk);
      vld = 1'b0; st = 1'b0; en = 1'b0;
    end
    repeat (400) @(negedge clk);
  endtask

  task automatic fill(input int v);
    for (int k = 0; k < 2048; k++) tr[k] = 8'(v);
  endtask

  task automatic ramp(input int e, input int hold, input int top);
    for (int i = 0; i < 6; i++) tr[e+i] = 8'(10 + 30 * i);
    for (int i = 6; i < hold; i++) tr[e+i] = 8'(top);
  endtask

  task automatic edges4(input int e1, input int e2, input int e3);
    fill(10);
    ramp(0, 60, 160); ramp(e1, 60, 160); ramp(e2, 60, 160); ramp(e3, 60, 160);
  endtask

  task automatic t_reset();
    check_slot("R1 reset", 0, 0);
    check_slot("R1 reset", 500, 0);
    check_slot("R1 reset", SLOTS - 1, 0);
  endtask

  task automatic t_aligned();
    edges4(240, 502, 753);
    send(1100, 1); model_add(1100);
    check_slot("R2 direct", 3, int'(tr[3]));
    check_slot("R4 steepest edge", 253, int'(tr[243]));
    check_slot("R6 block two", 500 + 6, int'(tr[508]));
    check_slot("R3 window spacing", 750 + 5, int'(tr[758]));
    check_all("R6 aligned trace");
  endtask

  task automatic t_second();
    edges4(260, 520, 790);
    send(1100, 1); model_add(1100);
    check_all("R9 summed traces");
  endtask

  task automatic t_clear();
    do_clear();
    check_all("R11 clear");
  endtask

  task automatic t_tie();
    fill(10);
    ramp(0, 60, 160); ramp(240, 20, 160); ramp(280, 20, 170);
    send(600, 1); model_add(600);
    check_slot("R4 tie earliest", 256, 160);
    check_all("R4 tie trace");
  endtask

  task automatic t_flat();
    for (int k = 0; k < 2048; k++) tr[k] = 8'(255 - k / 5);
    send(900, 1); model_add(900);
    check_slot("R5 fallback", 250, int'(tr[225]));
    check_slot("R5 fallback", 500, int'(tr[450]));
    check_slot("R5 fallback", 750, int'(tr[675]));
    check_all("R5 flat trace");
  endtask

  task automatic t_short();
    edges4(240, 502, 753);
    send(400, 1); model_add(400);
    check_slot("R7 partial last", 409, int'(tr[399]));
    check_slot("R7 partial stop", 410, 0);
    check_all("R7 partial trace");
    do_clear();
    send(300, 1); model_add(300);
    check_slot("R7 window incomplete", 250, 0);
    check_slot("R7 block zero", 249, int'(tr[249]));
  endtask

  task automatic t_stray();
    fill(99);
    send(50, 0);
    edges4(240, 502, 753);
    send(300, 1); model_add(300);
    fill(77);
    send(60, 0);
    check_slot("R10 stray after end", 250, 0);
    check_all("R10 stray samples");
  endtask

  task automatic t_full();
    edges4(240, 502, 753);
    ramp(1005, 60, 160);
    send(1300, 1); model_add(1300);
    check_slot("R8 last slot", SLOTS - 1, int'(tr[1002]));
    check_all("R8 full array");
  endtask

  initial begin
    zero_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_aligned();
    t_second();
    t_clear();
    t_tie();
    do_clear();
    t_flat();
    do_clear();
    t_short();
    do_clear();
    t_stray();
    do_clear();
    t_full();
    finish_run();
  end
endmodule